// File: doc/BRIEF.md
# Floppy Drive Track Register File

This block keeps a 16-bit present track number for each of four logical floppy drives. A command sequencer hands it a three-byte command over a byte-wide port qualified by a valid strobe. The block collects the three bytes and then performs one access on one byte of one drive's track number. That access is either a read or an overwrite. One cycle later the block returns a single result byte with a one-cycle valid pulse.

Two configuration inputs decide which drive codes are reachable. One input declares four-drive support. The other declares that drives 0 and 2 are exchanged. The stepping logic can also overwrite a whole track number through a separate load port. A load takes precedence over a command write that lands on the same drive in the same cycle.

Top module: `fdtrk_track_regs`

## Requirements
- R1: On a synchronous active-high reset, all eight stored track bytes become 0x00 and `res_valid` goes low.
- R2: Only bytes presented while `cmd_valid` is high count toward a command, and idle cycles may fall between them. After the third counted byte, `res_valid` is high for exactly one cycle, namely the cycle that follows that byte's clock edge.
- R3: Bit 6 of the first command byte selects the access: 0 reads the stored byte and 1 writes it.
- R4: In the second command byte, bits 1:0 give the drive code (00 to 11 select drives 0 to 3). Bit 2 selects the byte: 0 is the low byte (bits 7:0) and 1 is the high byte (bits 15:8).
- R5: On a read, the result is the selected stored byte. The third command byte is discarded and changes nothing.
- R6: On a write, the third command byte replaces the selected byte and is returned as the result. The other byte of that drive is unchanged, and so are the other drives.
- R7: Drive codes 00 and 01 are always reachable. Code 10 is reachable when `four_drv` or `swap_02` is high. Code 11 is reachable only when `four_drv` is high.
- R8: A command whose drive code is not reachable leaves all storage unchanged and returns 0x00, whether it is a read or a write.
- R9: When `ld_valid` is high, `ld_track` replaces the whole track number of drive `ld_drive` at that clock edge, whatever the configuration. If a command write targets the same drive in the same cycle, the load wins. A command write to a different drive still takes effect.
- R10: A read whose third byte coincides with a load to the same drive returns the value stored before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| four_drv | input | 1 | Four-drive support enabled |
| swap_02 | input | 1 | Drives 0 and 2 exchanged |
| ld_valid | input | 1 | Whole-track load strobe |
| ld_drive | input | 2 | Drive whose track number is loaded |
| ld_track | input | 16 | Track number to load |
| res_valid | output | 1 | One-cycle result strobe |
| res_byte | output | 8 | Result byte |

## Verification
A corrupted byte in storage stays hidden until a read command selects it. That byte then shows up wrongly in `res_byte` one cycle after the third command byte. For this reason the bench reads back every written byte, and also the untouched neighbouring bytes. A byte counter that slips out of step mis-frames every later command. That fault appears as a missing or doubled `res_valid` pulse, or as a wrong drive or byte being touched by the next command. The drive-enable logic is checked by showing that an unreachable code leaves storage intact once configuration later makes the code reachable.

// File: rtl/fdtrk_pkg.sv
package fdtrk_pkg;
  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_SELECT = 2'd1,
    PH_DATA   = 2'd2
  } fdtrk_phase_e;

  localparam int OP_BIT   = 6;
  localparam int HIGH_BIT = 2;
endpackage

// File: rtl/fdtrk_cmd_seq.sv
module fdtrk_cmd_seq
  import fdtrk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DRV_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_byte,
  output logic              exec,
  output logic              exec_wr,
  output logic [DRV_W-1:0]  exec_drv,
  output logic              exec_hi,
  output logic [DATA_W-1:0] exec_data
);
  fdtrk_phase_e       phase_q;
  logic               wr_q;
  logic [DRV_W-1:0]   drv_q;
  logic               hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OPCODE;
      wr_q    <= 1'b0;
      drv_q   <= '0;
      hi_q    <= 1'b0;
    end else if (cmd_valid) begin
      unique case (phase_q)
        PH_OPCODE: begin
          wr_q    <= cmd_byte[OP_BIT];
          phase_q <= PH_SELECT;
        end
        PH_SELECT: begin
          drv_q   <= cmd_byte[DRV_W-1:0];
          hi_q    <= cmd_byte[HIGH_BIT];
          phase_q <= PH_DATA;
        end
        default: phase_q <= PH_OPCODE;
      endcase
    end
  end

  assign exec      = cmd_valid && (phase_q == PH_DATA);
  assign exec_wr   = wr_q;
  assign exec_drv  = drv_q;
  assign exec_hi   = hi_q;
  assign exec_data = cmd_byte;

  // R2: the phase counter stays within the three command bytes
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q inside {PH_OPCODE, PH_SELECT, PH_DATA});

  // R2: an executed command restarts framing at the opcode byte
  assert_exec_restart_R2: assert property (@(posedge clk) disable iff (rst)
    exec |=> phase_q == PH_OPCODE);
endmodule

// File: rtl/fdtrk_drv_map.sv
module fdtrk_drv_map #(
  parameter int DRV_W = 2
) (
  input  logic [DRV_W-1:0] code,
  input  logic             four_drv,
  input  logic             swap_02,
  output logic             drv_en
);
  localparam logic [DRV_W-1:0] CODE_D2 = DRV_W'(2);
  localparam logic [DRV_W-1:0] CODE_D3 = DRV_W'(3);

  always_comb begin
    if (code == CODE_D3)      drv_en = four_drv;
    else if (code == CODE_D2) drv_en = four_drv | swap_02;
    else                      drv_en = 1'b1;
  end
endmodule

// File: rtl/fdtrk_store.sv
module fdtrk_store #(
  parameter int DATA_W  = 8,
  parameter int DRV_CNT = 4,
  localparam int DRV_W  = $clog2(DRV_CNT),
  localparam int TRK_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DRV_W-1:0]  wr_drv,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [DRV_W-1:0]  ld_drv,
  input  logic [TRK_W-1:0]  ld_word,
  input  logic [DRV_W-1:0]  rd_drv,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_data
);
  logic [DRV_CNT-1:0][TRK_W-1:0] words;

  for (genvar d = 0; d < DRV_CNT; d++) begin : g_drive
    logic [TRK_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (ld_en && ld_drv == DRV_W'(d)) begin
        word_q <= ld_word;
      end else if (wr_en && wr_drv == DRV_W'(d)) begin
        if (wr_hi) word_q[TRK_W-1:DATA_W] <= wr_data;
        else       word_q[DATA_W-1:0]     <= wr_data;
      end
    end
    assign words[d] = word_q;
  end

  logic [TRK_W-1:0] rd_word;
  assign rd_word = words[rd_drv];
  assign rd_data = rd_hi ? rd_word[TRK_W-1:DATA_W] : rd_word[DATA_W-1:0];

  // checker state: remembers the last load request
  logic             chk_ld_q;
  logic [DRV_W-1:0] chk_drv_q;
  logic [TRK_W-1:0] chk_word_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_ld_q   <= 1'b0;
      chk_drv_q  <= '0;
      chk_word_q <= '0;
    end else begin
      chk_ld_q   <= ld_en;
      chk_drv_q  <= ld_drv;
      chk_word_q <= ld_word;
    end
  end

  // R9: a load always lands in full, even against a same-cycle write
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    chk_ld_q |-> words[chk_drv_q] == chk_word_q);

  // R6: a write without a load changes one byte only
  assert_write_one_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ld_en) |=>
      (wr_hi ? words[$past(wr_drv)][DATA_W-1:0] == $past(words[wr_drv][DATA_W-1:0])
             : words[$past(wr_drv)][TRK_W-1:DATA_W] == $past(words[wr_drv][TRK_W-1:DATA_W])));
endmodule

// File: rtl/fdtrk_track_regs.sv
module fdtrk_track_regs #(
  parameter int DATA_W  = 8,
  parameter int DRV_CNT = 4,
  localparam int DRV_W  = $clog2(DRV_CNT),
  localparam int TRK_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              four_drv,
  input  logic              swap_02,
  input  logic              ld_valid,
  input  logic [DRV_W-1:0]  ld_drive,
  input  logic [TRK_W-1:0]  ld_track,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_byte
);
  logic              exec, exec_wr, exec_hi, drv_en;
  logic [DRV_W-1:0]  exec_drv;
  logic [DATA_W-1:0] exec_data, rd_data;

  fdtrk_cmd_seq #(.DATA_W(DATA_W), .DRV_W(DRV_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .exec(exec), .exec_wr(exec_wr), .exec_drv(exec_drv),
    .exec_hi(exec_hi), .exec_data(exec_data)
  );

  fdtrk_drv_map #(.DRV_W(DRV_W)) u_map (
    .code(exec_drv), .four_drv(four_drv), .swap_02(swap_02), .drv_en(drv_en)
  );

  logic wr_en;
  assign wr_en = exec && exec_wr && drv_en;

  fdtrk_store #(.DATA_W(DATA_W), .DRV_CNT(DRV_CNT)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_drv(exec_drv), .wr_hi(exec_hi), .wr_data(exec_data),
    .ld_en(ld_valid), .ld_drv(ld_drive), .ld_word(ld_track),
    .rd_drv(exec_drv), .rd_hi(exec_hi), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_byte  <= '0;
    end else begin
      res_valid <= exec;
      if (exec) begin
        if (!drv_en)      res_byte <= '0;
        else if (exec_wr) res_byte <= exec_data;
        else              res_byte <= rd_data;
      end
    end
  end

  // R2: result strobe never lasts two cycles
  assert_res_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8: an unreachable drive code yields a zero result
  assert_blocked_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (exec && !drv_en) |=> (res_valid && res_byte == '0));

  // R6: an accepted write echoes the third command byte
  assert_write_echo_R6: assert property (@(posedge clk) disable iff (rst)
    (exec && exec_wr && drv_en) |=> res_byte == $past(cmd_byte));
endmodule

// File: tb/tb_fdtrk_track_regs.sv
module tb_fdtrk_track_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic        four_drv, swap_02;
  logic        ld_valid;
  logic [1:0]  ld_drive;
  logic [15:0] ld_track;
  logic        res_valid;
  logic [7:0]  res_byte;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdtrk_track_regs dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .four_drv(four_drv), .swap_02(swap_02), .ld_valid(ld_valid),
    .ld_drive(ld_drive), .ld_track(ld_track),
    .res_valid(res_valid), .res_byte(res_byte)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one command; optional load is presented with the third byte.
  // gap inserts idle cycles between bytes.
  task automatic run_cmd(input logic wr, input logic [1:0] code, input logic hi,
                         input logic [7:0] data, input int gap,
                         input logic ld, input logic [1:0] ldd, input logic [15:0] ldw,
                         output logic [7:0] res);
    @(negedge clk); cmd_valid = 1; cmd_byte = {1'b0, wr, 6'b0};
    for (int i = 0; i < gap; i++) begin @(negedge clk); cmd_valid = 0; cmd_byte = 8'hFF; end
    @(negedge clk); cmd_valid = 1; cmd_byte = {5'b0, hi, code};
    for (int i = 0; i < gap; i++) begin @(negedge clk); cmd_valid = 0; cmd_byte = 8'hFF; end
    @(negedge clk); cmd_valid = 1; cmd_byte = data;
    ld_valid = ld; ld_drive = ldd; ld_track = ldw;
    @(negedge clk);
    cmd_valid = 0; ld_valid = 0;
    chk("R2 strobe after third byte", {15'b0, res_valid}, 16'd1);
    res = res_byte;
    @(negedge clk);
    chk("R2 strobe is one cycle", {15'b0, res_valid}, 16'd0);
  endtask

  task automatic rd(input logic [1:0] code, input logic hi, output logic [7:0] res);
    run_cmd(0, code, hi, 8'h00, 0, 0, 2'd0, 16'h0, res);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    rst = 1; cmd_valid = 0; cmd_byte = 0; four_drv = 1; swap_02 = 0;
    ld_valid = 0; ld_drive = 0; ld_track = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 res_valid low after reset", {15'b0, res_valid}, 16'd0);
    for (int d = 0; d < 4; d++)
      for (int h = 0; h < 2; h++) begin
        rd(2'(d), h[0], r);
        chk("R1 byte cleared", {8'h0, r}, 16'h0000);
      end
  endtask

  task automatic t_write_read;
    logic [7:0] r;
    run_cmd(1, 2'd1, 1, 8'hA5, 0, 0, 0, 0, r);
    chk("R6 write echoes data", {8'h0, r}, 16'h00A5);
    rd(2'd1, 1, r); chk("R3 R4 read drive1 high", {8'h0, r}, 16'h00A5);
    rd(2'd1, 0, r); chk("R6 drive1 low untouched", {8'h0, r}, 16'h0000);
    rd(2'd0, 1, r); chk("R6 drive0 high untouched", {8'h0, r}, 16'h0000);
    run_cmd(1, 2'd0, 0, 8'h3C, 0, 0, 0, 0, r);
    rd(2'd0, 0, r); chk("R4 drive0 low write", {8'h0, r}, 16'h003C);
    run_cmd(0, 2'd0, 0, 8'h77, 0, 0, 0, 0, r);
    chk("R5 read returns stored", {8'h0, r}, 16'h003C);
    rd(2'd0, 0, r); chk("R5 dummy byte discarded", {8'h0, r}, 16'h003C);
  endtask

  task automatic t_gaps;
    logic [7:0] r;
    run_cmd(1, 2'd3, 0, 8'h5A, 2, 0, 0, 0, r);
    chk("R2 gapped write echo", {8'h0, r}, 16'h005A);
    run_cmd(0, 2'd3, 0, 8'h00, 3, 0, 0, 0, r);
    chk("R2 gapped read", {8'h0, r}, 16'h005A);
  endtask

  task automatic t_config;
    logic [7:0] r;
    four_drv = 0; swap_02 = 0;
    run_cmd(1, 2'd2, 0, 8'h99, 0, 0, 0, 0, r);
    chk("R8 blocked write returns zero", {8'h0, r}, 16'h0000);
    rd(2'd3, 0, r); chk("R7 R8 code 11 blocked read zero", {8'h0, r}, 16'h0000);
    swap_02 = 1;
    rd(2'd2, 0, r); chk("R8 blocked write dropped", {8'h0, r}, 16'h0000);
    run_cmd(1, 2'd2, 1, 8'h42, 0, 0, 0, 0, r);
    chk("R7 code 10 via swap", {8'h0, r}, 16'h0042);
    run_cmd(1, 2'd3, 0, 8'hEE, 0, 0, 0, 0, r);
    chk("R7 code 11 needs four drives", {8'h0, r}, 16'h0000);
    four_drv = 1; swap_02 = 0;
    rd(2'd3, 0, r); chk("R8 drive3 unchanged by blocked write", {8'h0, r}, 16'h005A);
    rd(2'd2, 1, r); chk("R7 drive2 via four", {8'h0, r}, 16'h0042);
  endtask

  task automatic t_load;
    logic [7:0] r;
    four_drv = 0;
    @(negedge clk); ld_valid = 1; ld_drive = 2'd3; ld_track = 16'h1234;
    @(negedge clk); ld_valid = 0;
    four_drv = 1;
    rd(2'd3, 1, r); chk("R9 load high byte", {8'h0, r}, 16'h0012);
    rd(2'd3, 0, r); chk("R9 load low byte", {8'h0, r}, 16'h0034);
    run_cmd(1, 2'd1, 0, 8'hCC, 0, 1, 2'd1, 16'hBEEF, r);
    rd(2'd1, 0, r); chk("R9 load beats same-drive write", {8'h0, r}, 16'h00EF);
    rd(2'd1, 1, r); chk("R9 load sets high byte", {8'h0, r}, 16'h00BE);
    run_cmd(1, 2'd0, 1, 8'h81, 0, 1, 2'd2, 16'h0F0E, r);
    rd(2'd0, 1, r); chk("R9 other-drive write kept", {8'h0, r}, 16'h0081);
    rd(2'd2, 0, r); chk("R9 concurrent load other drive", {8'h0, r}, 16'h000E);
    run_cmd(0, 2'd2, 1, 8'h00, 0, 1, 2'd2, 16'hA1B2, r);
    chk("R10 read sees pre-load value", {8'h0, r}, 16'h000F);
    rd(2'd2, 1, r); chk("R10 load applied afterwards", {8'h0, r}, 16'h00A1);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_gaps();
    t_config();
    t_load();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule